// File: doc/BRIEF.md
# HDLC Receive Block Buffer

This block holds received HDLC frame bytes between the frame receiver and the host. The receiver side offers one byte per strobe, marks the first byte of a frame, and on a separate end strobe supplies the frame's status byte, which is stored right after the frame's last data byte. Up to 64 bytes are held, and any number of whole or partial frames may sit in the buffer together.

The write stream is cut into blocks. A block closes when it reaches the active block size, when a frame ends, or when a byte arrives with no free space. Each closed block becomes a service event (block-full, message-end or overflow) that carries its byte count. The events wait in a queue and the host sees one at a time. The host reads the bytes of the current block, then issues a release command. Release frees those bytes, moves to the next queued event and loads the block-size setting. A reset command empties everything and also loads the block-size setting.

Top module: `hdlc_rx_blkfifo`

## Requirements
- R1: The buffer holds 64 bytes. Data and status bytes are read back through `rd_data` in the order they were written, across block and frame boundaries, and several frames may be held at once.
- R2: The block size is set by `cfg_bsize`: 2'b00 gives 32 bytes, 2'b01 gives 16, 2'b10 gives 8 and 2'b11 gives 4. After power-on reset the block size is 32.
- R3: A new `cfg_bsize` value takes effect only when a release command is accepted or a reset command is issued. Until then, blocks keep closing at the old size.
- R4: When the data bytes of the open block reach the block size, a block-full event is queued with `irq_kind` = 2'b01 and `irq_len` equal to that byte count.
- R5: An end strobe stores its status byte after the frame's data. It queues a message-end event with `irq_kind` = 2'b10 and `irq_len` = (data bytes in the open block) + 1, even when that count is below the block size.
- R6: Events are presented one at a time in the order they were queued. Once a release is accepted, the next queued event appears on `irq_valid`/`irq_kind`/`irq_len` in the very next cycle.
- R7: `rd_en` advances the read position only while it lies inside the current block. A strobe past `irq_len` bytes leaves `rd_data` unchanged. Release frees exactly `irq_len` bytes.
- R8: A write that arrives while 64 bytes are occupied is not stored. It queues an overflow event with `irq_kind` = 2'b11 and `irq_len` = the data bytes of the open block (0 if that block had just closed). All later data and end strobes are dropped until a write with `wr_sof` set.
- R9: `cmd_reset` empties the buffer, discards every queued event, ends any discard state and loads the block size from `cfg_bsize`. `irq_valid` is low in the following cycle.
- R10: After `rst_n` is released, `irq_valid` is low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Byte strobe from the frame receiver |
| wr_sof | input | 1 | Marks the strobed byte as the first of a frame |
| wr_end | input | 1 | The strobed byte is the frame's status byte (frame end) |
| wr_data | input | 8 | Data or status byte |
| cfg_bsize | input | 2 | Block-size setting, loaded on release or reset command |
| cmd_release | input | 1 | Release the current block and move to the next event |
| cmd_reset | input | 1 | Empty the buffer and the event queue |
| rd_en | input | 1 | Advance the read position by one byte |
| rd_data | output | 8 | Byte at the current read position |
| irq_valid | output | 1 | A service event is pending |
| irq_kind | output | 2 | Event type: 01 block-full, 10 message-end, 11 overflow |
| irq_len | output | 7 | Byte count of the current block |

## Verification
The hardest state to reach is overflow followed by discard. It needs the buffer completely full with no host service, then extra bytes of the same frame and an end strobe that must all vanish, then a frame start that must be accepted again. The stimulus writes one long frame with the host idle until the 65th byte. It then services the two full blocks and the zero-length overflow event. After that it sends a byte and an end strobe without a frame start, confirms that no event appears, and only then starts a fresh frame. The deferred block-size load is reached by changing the setting while an older frame is still queued and checking that the older frame closes at the old size.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
    localparam int LEN_W = 7;

    typedef enum logic [1:0] {
        EV_NONE   = 2'b00,
        EV_BLOCK  = 2'b01,
        EV_MSGEND = 2'b10,
        EV_OVFL   = 2'b11
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e          kind;
        logic [LEN_W-1:0]  len;
    } ev_t;

    // Block size from the 2-bit setting: 32 >> setting
    function automatic logic [LEN_W-1:0] blk_bytes(input logic [1:0] sel);
        return 7'd32 >> sel;
    endfunction
endpackage

// File: rtl/hrf_store.sv
module hrf_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/hrf_evq.sv
module hrf_evq
    import hrf_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic push,
    input  ev_t  push_ev,
    input  logic pop,
    output logic head_valid,
    output ev_t  head_ev
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [AW:0]   cnt;
    } st_t;

    st_t  q, d;
    logic do_push, do_pop;
    ev_t  slot_q [DEPTH];

    always_comb begin
        d       = q;
        do_pop  = pop && (q.cnt != '0);
        do_push = push && (q.cnt != (AW+1)'(DEPTH));
        if (clr) begin
            d       = '0;
            do_push = 1'b0;
            do_pop  = 1'b0;
        end else begin
            if (do_push) d.wr = q.wr + 1'b1;
            if (do_pop)  d.rd = q.rd + 1'b1;
            d.cnt = q.cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) slot_q[q.wr] <= push_ev;
    end

    assign head_valid = (q.cnt != '0);
    assign head_ev    = slot_q[q.rd];

    AST_EVQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= (AW+1)'(DEPTH)); // R6
    AST_EVQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && pop && head_valid && !push) |=> (q.cnt == $past(q.cnt) - 1'b1)); // R6
endmodule

// File: rtl/hdlc_rx_blkfifo.sv
module hdlc_rx_blkfifo
    import hrf_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int EVQ_DEP = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             wr_sof,
    input  logic             wr_end,
    input  logic [7:0]       wr_data,
    input  logic [1:0]       cfg_bsize,
    input  logic             cmd_release,
    input  logic             cmd_reset,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             irq_valid,
    output logic [1:0]       irq_kind,
    output logic [LEN_W-1:0] irq_len
);
    localparam int AW    = $clog2(DEPTH);
    localparam int OCC_W = AW + 1;

    typedef struct packed {
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [AW-1:0]    bp;
        logic [OCC_W-1:0] occ;
        logic [LEN_W-1:0] seg;
        logic [LEN_W-1:0] thr;
        logic             discard;
    } st_t;

    st_t              q, d;
    logic             mem_we, ev_push, ev_pop, head_valid, inc;
    logic [LEN_W-1:0] dec;
    logic [AW-1:0]    roff;
    ev_t              ev_new, head_ev;

    assign roff = q.rp - q.bp;

    always_comb begin
        d       = q;
        mem_we  = 1'b0;
        ev_push = 1'b0;
        ev_pop  = 1'b0;
        ev_new  = '{kind: EV_NONE, len: '0};
        inc     = 1'b0;
        dec     = '0;
        if (cmd_reset) begin
            d = '{wp: '0, rp: '0, bp: '0, occ: '0, seg: '0,
                  thr: blk_bytes(cfg_bsize), discard: 1'b0};
        end else begin
            // write side: segment the stream into blocks
            if (wr_valid && (!q.discard || wr_sof)) begin
                d.discard = 1'b0;
                if (q.occ == OCC_W'(DEPTH)) begin
                    ev_push   = 1'b1;
                    ev_new    = '{kind: EV_OVFL, len: q.seg};
                    d.seg     = '0;
                    d.discard = 1'b1;
                end else begin
                    mem_we = 1'b1;
                    inc    = 1'b1;
                    d.wp   = q.wp + 1'b1;
                    if (wr_end) begin
                        ev_push = 1'b1;
                        ev_new  = '{kind: EV_MSGEND, len: q.seg + 1'b1};
                        d.seg   = '0;
                    end else if ((q.seg + 1'b1) >= q.thr) begin
                        ev_push = 1'b1;
                        ev_new  = '{kind: EV_BLOCK, len: q.seg + 1'b1};
                        d.seg   = '0;
                    end else begin
                        d.seg = q.seg + 1'b1;
                    end
                end
            end
            // host side: release or read
            if (cmd_release && head_valid) begin
                ev_pop = 1'b1;
                dec    = head_ev.len;
                d.bp   = q.bp + AW'(head_ev.len);
                d.rp   = q.bp + AW'(head_ev.len);
                d.thr  = blk_bytes(cfg_bsize);
            end else if (rd_en && head_valid && (LEN_W'(roff) < head_ev.len)) begin
                d.rp = q.rp + 1'b1;
            end
            d.occ = q.occ + OCC_W'(inc) - OCC_W'(dec);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{wp: '0, rp: '0, bp: '0, occ: '0, seg: '0,
                   thr: blk_bytes(2'b00), discard: 1'b0};
        else
            q <= d;
    end

    hrf_store #(.DEPTH(DEPTH), .DW(8), .AW(AW)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (q.wp),
        .wdata (wr_data),
        .raddr (q.rp),
        .rdata (rd_data)
    );

    hrf_evq #(.DEPTH(EVQ_DEP)) u_evq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cmd_reset),
        .push       (ev_push),
        .push_ev    (ev_new),
        .pop        (ev_pop),
        .head_valid (head_valid),
        .head_ev    (head_ev)
    );

    assign irq_valid = head_valid;
    assign irq_kind  = head_ev.kind;
    assign irq_len   = head_ev.len;

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.occ <= OCC_W'(DEPTH)); // R1
    AST_THR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_release && !cmd_reset) |=> $stable(q.thr)); // R3
    AST_RD_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (LEN_W'(roff) <= irq_len)); // R7
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.occ == OCC_W'(DEPTH) && !cmd_release && !cmd_reset) |=> (q.occ == OCC_W'(DEPTH))); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (q.occ == '0 && !irq_valid)); // R9
endmodule

// File: tb/hdlc_rx_blkfifo_tb.sv
module hdlc_rx_blkfifo_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_valid, wr_sof, wr_end, cmd_release, cmd_reset, rd_en;
    logic [7:0] wr_data, rd_data;
    logic [1:0] cfg_bsize, irq_kind;
    logic       irq_valid;
    logic [6:0] irq_len;

    always #10 clk = ~clk;

    hdlc_rx_blkfifo u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sof(wr_sof),
        .wr_end(wr_end), .wr_data(wr_data), .cfg_bsize(cfg_bsize),
        .cmd_release(cmd_release), .cmd_reset(cmd_reset), .rd_en(rd_en),
        .rd_data(rd_data), .irq_valid(irq_valid), .irq_kind(irq_kind),
        .irq_len(irq_len)
    );

    typedef struct { int kind; int len; } xev_t;
    xev_t       exp_ev[$];
    logic [7:0] exp_by[$];
    int n_cmp = 0, n_bad = 0;
    int seg_m, thr_m;
    logic [7:0] pat;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic wr_byte(input logic [7:0] v, input bit sof, input bit eof);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = v; wr_sof = sof; wr_end = eof;
        @(negedge clk);
        wr_valid = 1'b0; wr_sof = 1'b0; wr_end = 1'b0;
    endtask

    // driver: writes a frame and pushes what the host must later see
    task automatic send_frame(input int n);
        for (int i = 0; i < n; i++) begin
            pat++;
            wr_byte(pat, i == 0, 1'b0);
            exp_by.push_back(pat);
            seg_m++;
            if (seg_m >= thr_m) begin
                exp_ev.push_back('{1, seg_m});
                seg_m = 0;
            end
        end
        pat++;
        wr_byte(pat, n == 0, 1'b1);
        exp_by.push_back(pat);
        exp_ev.push_back('{2, seg_m + 1});
        seg_m = 0;
    endtask

    task automatic pulse_reset(input logic [1:0] sel);
        @(negedge clk);
        cfg_bsize = sel; cmd_reset = 1'b1;
        @(negedge clk);
        cmd_reset = 1'b0;
        chk(irq_valid == 1'b0, "R9", "irq_valid after reset cmd", irq_valid, 0);
        exp_ev.delete(); exp_by.delete();
        seg_m = 0; thr_m = 32 >> sel;
    endtask

    // monitor: pops the next expected event and compares the host view
    task automatic serve(input string req);
        xev_t e;
        int w;
        logic [7:0] b, hold;
        e = exp_ev.pop_front();
        w = 0;
        @(negedge clk);
        while (!irq_valid && w < 500) begin
            @(negedge clk);
            w++;
        end
        chk(irq_valid == 1'b1, req, "irq_valid", irq_valid, 1);
        chk(int'(irq_kind) == e.kind, req, "irq_kind", irq_kind, e.kind);
        chk(int'(irq_len) == e.len, req, "irq_len", irq_len, e.len);
        for (int i = 0; i < e.len; i++) begin
            b = exp_by.pop_front();
            chk(rd_data == b, "R1", "rd_data", rd_data, b);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        hold = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data == hold, "R7", "rd_data after read past block", rd_data, hold);
        cmd_release = 1'b1;
        @(negedge clk);
        cmd_release = 1'b0;
        thr_m = 32 >> cfg_bsize;
        if (exp_ev.size() > 0)
            chk(irq_valid == 1'b1, "R6", "next event raised after release", irq_valid, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R6 watchdog expired: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_valid = 1'b0; wr_sof = 1'b0; wr_end = 1'b0; wr_data = '0;
        cfg_bsize = 2'b00; cmd_release = 1'b0; cmd_reset = 1'b0; rd_en = 1'b0;
        seg_m = 0; thr_m = 32; pat = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_valid == 1'b0, "R10", "irq_valid after reset", irq_valid, 0);

        // R2 default 32, R4 block-full, R5 message end
        send_frame(40);
        serve("R4");
        serve("R5");

        // R3: new size written, older frame still closes at 32
        cfg_bsize = 2'b11;
        send_frame(6);
        serve("R3");
        send_frame(10);
        serve("R2");
        serve("R2");
        serve("R2");

        // R6: several frames queued together
        send_frame(2);
        send_frame(3);
        send_frame(0);
        serve("R6");
        serve("R6");
        serve("R6");

        // R9: reset command mid-frame, size 16
        for (int i = 0; i < 5; i++) begin
            pat++;
            wr_byte(pat, i == 0, 1'b0);
        end
        pulse_reset(2'b01);
        send_frame(20);
        serve("R9");
        serve("R9");

        // R2: size 8
        pulse_reset(2'b10);
        send_frame(9);
        serve("R2");
        serve("R2");

        // R8: overflow and discard
        pulse_reset(2'b00);
        for (int i = 1; i <= 70; i++) begin
            pat++;
            wr_byte(pat, i == 1, 1'b0);
            if (i <= 64) begin
                exp_by.push_back(pat);
                seg_m++;
                if (seg_m >= thr_m) begin
                    exp_ev.push_back('{1, seg_m});
                    seg_m = 0;
                end
            end
        end
        exp_ev.push_back('{3, 0});
        pat++;
        wr_byte(pat, 1'b0, 1'b1);
        serve("R8");
        serve("R8");
        serve("R8");
        pat++;
        wr_byte(pat, 1'b0, 1'b0);
        pat++;
        wr_byte(pat, 1'b0, 1'b1);
        @(negedge clk);
        chk(irq_valid == 1'b0, "R8", "writes dropped before frame start", irq_valid, 0);
        seg_m = 0;
        send_frame(3);
        serve("R8");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule